// File: doc/BRIEF.md
# Walking-One SRAM Mapping Pattern Sequencer

This block drives the pins of a static RAM under test with a stimulus that is locked to an external video timing signal. The sequence lets an observer tell which address bits select rows and which select columns, and how far apart the selected lines lie. In a sweep, the address starts at zero and then raises one address bit at a time. The run of states is spread evenly over the interval between two sync pulses. Column sweeps are restarted by frame sync and row sweeps by line sync. Throughout the pattern the device is selected and held in write mode. The data word is constant, either all zeros or all ones.

Two alternating modes provide two-state stimulus with a phase reference. In the first, the address swaps between zero and a single chosen bit while the data stays fixed. In the second, the address stays at zero while the data word swaps between zero and a single chosen data bit. In both, the level of the chosen bit is driven on a reference output. The bits walked in a row sweep come from a mask. Mode, mask, polarity and bit index are captured at each selected sync pulse, so one pass always uses one configuration.

The controller has three states. ST_IDLE is the state after reset, with the device deselected. ST_STEP walks through the pattern states. ST_LAST holds the final pattern state. Any selected sync moves ST_IDLE, ST_STEP or ST_LAST to ST_STEP at pattern index 0. ST_STEP advances the index after each slot of cycles, and moves to ST_LAST once the index reaches the final state. ST_LAST stays put until the next sync.

Top module: `wo_map_sequencer`

## Requirements
- R1: After reset and before the first selected sync, sram_en_n=1, sram_we_n=1, and sram_addr, sram_data and phase_ref are all 0.
- R2: From the cycle after the first selected sync onward, sram_en_n=0 and sram_we_n=0 every cycle.
- R3: Mode 2'b00 (column sweep, restarted by frame_sync) presents S=ADDR_W+1 states. State 0 is address 0, and state j (j>=1) is address 1<<(j-1), so bit 0 comes first and bit ADDR_W-1 last.
- R4: Mode 2'b01 (row sweep, restarted by line_sync) presents address 0 and then, in ascending bit order, a one-hot address for each bit set in row_mask, so S=1+popcount(row_mask). With an empty mask the address stays 0.
- R5: In modes 2'b00, 2'b01 and 2'b10 the data word is all ones when data_ones=1 and all zeros when data_ones=0. phase_ref is 0 in both sweep modes.
- R6: Let P be the number of cycles between the two most recent selected sync pulses (DEF_PERIOD before any interval has been measured). Each state then lasts max(floor(P/S),1) cycles, and the final state holds until the next selected sync. If a selected sync arrives k cycles after the previous one (k=0 being the sync cycle), the index shown is min(floor(k/slot), S-1).
- R7: Mode 2'b10 (address alternation, frame_sync) has S=2: address 0, then address 1<<alt_index. phase_ref equals the level of address bit alt_index.
- R8: Mode 2'b11 (data alternation, frame_sync) has S=2. The address is held at 0 and the data word is 0, then 1<<alt_index, whatever data_ones is. phase_ref equals the level of data bit alt_index.
- R9: A selected sync at any point restarts the pattern: in the next cycle the index is 0, so the address is 0. A pulse on the sync input that the current mode does not select has no effect.
- R10: data_ones, row_mask, alt_index and the pattern kind are sampled only on a selected sync. Changing them during a pass does not alter that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame sync pulse; restarts modes 00, 10, 11 |
| line_sync | input | 1 | Line sync pulse; restarts mode 01 |
| mode | input | 2 | Pattern kind: 00 column sweep, 01 row sweep, 10 address alternation, 11 data alternation |
| data_ones | input | 1 | Data polarity: 1 for all ones, 0 for all zeros |
| row_mask | input | ADDR_W | Address bits walked in a row sweep |
| alt_index | input | SEL_W | Bit index used by the alternating modes |
| sram_addr | output | ADDR_W | Address bus to the device under test |
| sram_data | output | DATA_W | Data bus to the device under test |
| sram_en_n | output | 1 | Active-low device enable |
| sram_we_n | output | 1 | Read/write control, 0 selects write |
| phase_ref | output | 1 | Level of the alternated bit |

## Verification
A wrong pattern index, or a wrong dwell count, shows at sram_addr as the wrong one-hot bit or a bit that lasts the wrong number of cycles. The error appears in the first cycle past the affected slot boundary. A fault in sync handling or in capturing the period shows in the cycle after the next sync, either as a non-zero address or as a slot length that does not match the measured interval. The bench compares the packed enable, write, reference, address and data outputs in every cycle of every pass against an index computed from the pass length. It covers all sixteen row masks, every alternation index, and leftover, truncated and very short periods.

// File: rtl/wo_map_pkg.sv
package wo_map_pkg;
    typedef enum logic [1:0] {
        MODE_COL_SWEEP = 2'd0,
        MODE_ROW_SWEEP = 2'd1,
        MODE_ADDR_ALT  = 2'd2,
        MODE_DATA_ALT  = 2'd3
    } pat_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_LAST = 2'd2
    } seq_state_e;
endpackage

// File: rtl/wo_sync_period_meter.sv
module wo_sync_period_meter #(
    parameter int CNT_W      = 16,
    parameter int DEF_PERIOD = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    output logic [CNT_W-1:0] period_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;

    // cycles since the last sync; captured as the period at the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            seen_q   <= 1'b0;
            period_q <= CNT_W'(DEF_PERIOD);
        end else if (sync) begin
            cnt_q    <= CNT_W'(1);
            seen_q   <= 1'b1;
            if (seen_q) period_q <= cnt_q;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R6: the interval count restarts at one after every sync
    p_count_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (cnt_q == CNT_W'(1)));

    // R6: the period only changes on a sync
    p_period_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> $stable(period_q));
endmodule

// File: rtl/wo_walk_decoder.sv
module wo_walk_decoder
    import wo_map_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    parameter int IDX_W  = 3,
    parameter int SEL_W  = 2
) (
    input  pat_mode_e         mode,
    input  logic [ADDR_W-1:0] mask,
    input  logic [SEL_W-1:0]  sel,
    input  logic              pol,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              ref_bit,
    output logic [IDX_W-1:0]  n_states
);
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
    localparam logic [DATA_W-1:0] ONE_D = DATA_W'(1);

    logic [ADDR_W-1:0] walk;
    logic [ADDR_W-1:0] addr_sw;
    logic [IDX_W-1:0]  n_walk;
    logic [ADDR_W-1:0] alt_a;
    logic [DATA_W-1:0] alt_d;

    assign walk  = (mode == MODE_COL_SWEEP) ? '1 : mask;
    assign alt_a = ONE_A << sel;
    assign alt_d = ONE_D << sel;

    // j-th walked bit (ascending) is lit for index j; index 0 lights none
    always_comb begin
        addr_sw = '0;
        n_walk  = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (walk[b]) begin
                n_walk = n_walk + IDX_W'(1);
                if (n_walk == idx) addr_sw[b] = 1'b1;
            end
        end
    end

    always_comb begin
        addr     = '0;
        data     = pol ? '1 : '0;
        ref_bit  = 1'b0;
        n_states = IDX_W'(2);
        unique case (mode)
            MODE_COL_SWEEP, MODE_ROW_SWEEP: begin
                addr     = addr_sw;
                n_states = n_walk + IDX_W'(1);
            end
            MODE_ADDR_ALT: begin
                addr    = (idx != '0) ? alt_a : '0;
                ref_bit = |addr;
            end
            MODE_DATA_ALT: begin
                data    = (idx != '0) ? alt_d : '0;
                ref_bit = |data;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wo_map_sequencer.sv
module wo_map_sequencer
    import wo_map_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 4,
    parameter int CNT_W      = 16,
    parameter int DEF_PERIOD = 40,
    localparam int MAX_W     = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
    localparam int SEL_W     = (MAX_W > 1) ? $clog2(MAX_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              line_sync,
    input  logic [1:0]        mode,
    input  logic              data_ones,
    input  logic [ADDR_W-1:0] row_mask,
    input  logic [SEL_W-1:0]  alt_index,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_data,
    output logic              sram_en_n,
    output logic              sram_we_n,
    output logic              phase_ref
);
    localparam int IDX_W = $clog2(ADDR_W + 2);

    seq_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  dwell_q;
    pat_mode_e         mode_q;
    logic [ADDR_W-1:0] mask_q;
    logic [SEL_W-1:0]  sel_q;
    logic              pol_q;

    logic              sync_sel;
    logic [CNT_W-1:0]  period_q;
    logic [CNT_W-1:0]  slot;
    logic [CNT_W-1:0]  slot_eff;
    logic [ADDR_W-1:0] dec_addr;
    logic [DATA_W-1:0] dec_data;
    logic              dec_ref;
    logic [IDX_W-1:0]  n_states;

    // live mode picks which sync restarts the pattern
    assign sync_sel = (pat_mode_e'(mode) == MODE_ROW_SWEEP) ? line_sync : frame_sync;

    wo_sync_period_meter #(
        .CNT_W      (CNT_W),
        .DEF_PERIOD (DEF_PERIOD)
    ) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync     (sync_sel),
        .period_q (period_q)
    );

    wo_walk_decoder #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .SEL_W  (SEL_W)
    ) u_dec (
        .mode     (mode_q),
        .mask     (mask_q),
        .sel      (sel_q),
        .pol      (pol_q),
        .idx      (idx_q),
        .addr     (dec_addr),
        .data     (dec_data),
        .ref_bit  (dec_ref),
        .n_states (n_states)
    );

    // slot length: period split evenly, leftover stays with the last state
    assign slot     = period_q / CNT_W'(n_states);
    assign slot_eff = (slot == '0) ? CNT_W'(1) : slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            dwell_q <= '0;
            mode_q  <= MODE_COL_SWEEP;
            mask_q  <= '0;
            sel_q   <= '0;
            pol_q   <= 1'b0;
        end else if (sync_sel) begin
            state_q <= ST_STEP;
            idx_q   <= '0;
            dwell_q <= '0;
            mode_q  <= pat_mode_e'(mode);
            mask_q  <= row_mask;
            sel_q   <= alt_index;
            pol_q   <= data_ones;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_q <= ST_IDLE;
                end
                ST_STEP: begin
                    if (idx_q >= n_states - IDX_W'(1)) begin
                        state_q <= ST_LAST;
                    end else if (dwell_q == slot_eff - CNT_W'(1)) begin
                        idx_q   <= idx_q + IDX_W'(1);
                        dwell_q <= '0;
                    end else begin
                        dwell_q <= dwell_q + CNT_W'(1);
                    end
                end
                ST_LAST: begin
                    state_q <= ST_LAST;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_STEP, ST_LAST: begin
                sram_addr = dec_addr;
                sram_data = dec_data;
                sram_en_n = 1'b0;
                sram_we_n = 1'b0;
                phase_ref = dec_ref;
            end
            default: begin
                sram_addr = '0;
                sram_data = '0;
                sram_en_n = 1'b1;
                sram_we_n = 1'b1;
                phase_ref = 1'b0;
            end
        endcase
    end

    // R2: the device is only selected after a sync, and stays selected
    p_select_after_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_en_n && $past(sram_en_n)) |-> $past(sync_sel));
    p_select_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_en_n |=> (!sram_en_n && !sram_we_n));

    // R3: never more than one address bit raised
    p_addr_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sram_addr));

    // R9: a selected sync brings address 0 in the following cycle
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_sel |=> (sram_addr == '0 && !sram_en_n));

    // R6: index moves by at most one between syncs, dwell stays inside a slot
    p_walk_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !sync_sel) |=>
            (idx_q == $past(idx_q) || idx_q == $past(idx_q) + IDX_W'(1)));
    p_dwell_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |-> (dwell_q < slot_eff));
    p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (idx_q < n_states));

    // R7: reference follows the raised address bit in address alternation
    p_ref_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && mode_q == MODE_ADDR_ALT) |-> (phase_ref == |sram_addr));
endmodule

// File: tb/wo_map_sequencer_tb.sv
module wo_map_sequencer_tb;
    localparam int AW  = 4;
    localparam int DW  = 4;
    localparam int DEF = 40;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          frame_sync, line_sync;
    logic [1:0]    mode;
    logic          data_ones;
    logic [AW-1:0] row_mask;
    logic [1:0]    alt_index;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_data;
    logic          sram_en_n, sram_we_n, phase_ref;

    int n_cmp = 0;
    int n_bad = 0;
    int last_len = DEF;
    bit done = 1'b0;

    localparam logic [10:0] IDLE_VEC = 11'b110_0000_0000;

    always #4 clk = ~clk;

    wo_map_sequencer #(
        .ADDR_W (AW), .DATA_W (DW), .CNT_W (16), .DEF_PERIOD (DEF)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .frame_sync (frame_sync), .line_sync (line_sync),
        .mode (mode), .data_ones (data_ones), .row_mask (row_mask), .alt_index (alt_index),
        .sram_addr (sram_addr), .sram_data (sram_data), .sram_en_n (sram_en_n),
        .sram_we_n (sram_we_n), .phase_ref (phase_ref)
    );

    function automatic logic [10:0] outs();
        return {sram_en_n, sram_we_n, phase_ref, sram_addr, sram_data};
    endfunction

    task automatic check(input logic [10:0] got, input logic [10:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    function automatic int n_states_of(input logic [1:0] m, input logic [3:0] msk);
        int c;
        if (m >= 2'd2) return 2;
        if (m == 2'd0) return AW + 1;
        c = 1;
        for (int b = 0; b < AW; b++) if (msk[b]) c++;
        return c;
    endfunction

    function automatic logic [10:0] model(input logic [1:0] m, input logic [3:0] msk,
                                          input int sel, input logic pol, input int idx);
        logic [3:0] a, d;
        logic r;
        int c;
        a = 4'h0; d = pol ? 4'hF : 4'h0; r = 1'b0; c = 0;
        case (m)
            2'd0: if (idx > 0) a = 4'(1) << (idx - 1);
            2'd1: for (int b = 0; b < AW; b++) if (msk[b]) begin
                      c++;
                      if (c == idx) a[b] = 1'b1;
                  end
            2'd2: if (idx > 0) begin a = 4'(1) << sel; r = 1'b1; end
            default: begin
                d = 4'h0;
                if (idx > 0) begin d = 4'(1) << sel; r = 1'b1; end
            end
        endcase
        return {2'b00, r, a, d};
    endfunction

    // One pass of len cycles started by a selected sync; disturb pulses the
    // other sync and changes the captured configuration halfway through.
    task automatic run_seq(input int len, input logic [1:0] m, input logic [3:0] msk,
                           input int sel, input logic pol, input string tag, input bit disturb);
        int s, slot, idx;
        string t;
        s = n_states_of(m, msk);
        slot = last_len / s;
        if (slot < 1) slot = 1;
        for (int k = 0; k < len; k++) begin
            if (k == 0) begin
                mode = m; row_mask = msk; alt_index = 2'(sel); data_ones = pol;
                if (m == 2'd1) line_sync = 1'b1; else frame_sync = 1'b1;
            end
            if (disturb && k == len / 2) begin
                if (m == 2'd1) frame_sync = 1'b1; else line_sync = 1'b1;
                row_mask = ~msk; alt_index = 2'(sel + 1); data_ones = ~pol;
            end
            @(posedge clk); #2;
            frame_sync = 1'b0; line_sync = 1'b0;
            idx = k / slot;
            if (idx > s - 1) idx = s - 1;
            t = (k == 0) ? {"R9 R2 ", tag} : (disturb ? {"R10 R9 ", tag} : {"R6 ", tag});
            check(outs(), model(m, msk, sel, pol, idx), t);
        end
        last_len = len;
    endtask

    initial begin
        rst_n = 1'b0; frame_sync = 1'b0; line_sync = 1'b0;
        mode = 2'd0; data_ones = 1'b0; row_mask = 4'h0; alt_index = 2'd0;
        repeat (3) @(posedge clk);
        #2 check(outs(), IDLE_VEC, "R1 in reset");
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #2;
            check(outs(), IDLE_VEC, "R1 idle");
        end
        // unselected sync while idle: still idle
        line_sync = 1'b1;
        @(posedge clk); #2; line_sync = 1'b0;
        check(outs(), IDLE_VEC, "R9 R1 unselected sync");
        @(posedge clk); #2;
        check(outs(), IDLE_VEC, "R9 R1 unselected sync");

        run_seq(40, 2'd0, 4'h0, 0, 1'b0, "R3 default period", 0);
        run_seq(23, 2'd0, 4'h0, 0, 1'b1, "R5 R3 ones", 0);
        run_seq(37, 2'd0, 4'h0, 0, 1'b0, "R6 R3 leftover", 0);
        for (int mk = 0; mk < 16; mk++)
            run_seq(30, 2'd1, 4'(mk), 0, mk[0], "R4 R5 row mask", 0);
        run_seq(3, 2'd0, 4'h0, 0, 1'b0, "R6 short", 0);
        run_seq(20, 2'd0, 4'h0, 0, 1'b0, "R6 min slot", 0);
        for (int sl = 0; sl < 4; sl++)
            run_seq(16, 2'd2, 4'h0, sl, sl[0], "R7 R5 addr alt", 0);
        for (int sl = 0; sl < 4; sl++)
            run_seq(16, 2'd3, 4'h0, sl, 1'b1, "R8 data alt", 0);
        run_seq(40, 2'd0, 4'h0, 0, 1'b0, "R3 resettle", 0);
        run_seq(40, 2'd0, 4'h5, 1, 1'b1, "R10 column", 1);
        run_seq(30, 2'd1, 4'b1010, 0, 1'b0, "R10 R4 row", 1);
        run_seq(16, 2'd2, 4'h0, 2, 1'b0, "R10 R7 alt", 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R6: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule